// File: doc/BRIEF.md
# Dual-Pipe Issue Group Controller

This block sits after decode and decides, every cycle, how many of the two oldest decoded instructions may enter a pair of integer pipes, named S and T. Each slot carries a small class tag. The tag gives the execution unit, whether the instruction needs one pipe or both, a branch flag, and a multi-cycle flag for call-type and load/store-multiple operations. It also gives a data-dependence hint: slot 0 can be marked as a forwarding producer, and slot 1 can be marked as a superscalar reader that depends on slot 0.

The block keeps a draining shadow for each execution unit: fixed-point, binary floating point, and decimal floating point. The shadow models the dispatch gap that a change of unit costs. An instruction that would switch units while another unit's shadow still holds an occupied stage is stalled. A stream that stays on one unit is never delayed by its own shadow.

The outputs are a grant per slot, the pipes each granted slot uses, and a stall flag for the oldest slot. Issue is strictly in program order. When the pair cannot go together, slot 0 goes alone and the caller presents slot 1 again as the next oldest instruction.

Top module: `dual_issue_gate`

## Requirements
- R1: A synchronous reset clears every unit shadow and the multi-cycle hold. The first instruction of any unit presented after reset issues in the same cycle.
- R2: Two compatible valid slots issue together. Slot 0 reports pipe code 2'b01 (S) and slot 1 reports 2'b10 (T). A slot that is not granted reports 2'b00.
- R3: An instruction flagged as needing both pipes, or flagged as multi-cycle, issues alone with pipe code 2'b11. A slot 1 with either flag is never paired.
- R4: A branch pairs with a non-branch, but two branches never issue in the same cycle.
- R5: Slot 1 is never granted unless slot 0 is granted in the same cycle. The stall output is high exactly when slot 0 is valid and not granted.
- R6: When slot 1 depends on slot 0, the pair issues only if slot 0 is marked as a forwarding producer and slot 1 is marked superscalar. Otherwise only slot 0 issues.
- R7: Unit codes are 2'b00 fixed-point, 2'b01 binary FP (which also carries integer multiply and divide), and 2'b10 decimal FP. An instruction for one unit issued in cycle t blocks any other unit for the next FX_GAP (6), BF_GAP (13) or DF_GAP (7) cycles, according to the issuing unit. The blocked instruction issues in the first cycle after that window.
- R8: Instructions for the same unit issue in back-to-back cycles without any stall.
- R9: After a multi-cycle instruction issues, no instruction issues for the next HOLD_CYCLES-1 (3) cycles.
- R10: Two slots for different units are never paired. Slot 0 issues alone.
- R11: Unit code 2'b11 is treated as fixed-point, for both pairing and the shadow gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s0Valid | input | 1 | Slot 0 holds an instruction |
| s0Unit | input | 2 | Slot 0 execution unit code |
| s0Both | input | 1 | Slot 0 needs both pipes |
| s0Branch | input | 1 | Slot 0 is a branch |
| s0Multi | input | 1 | Slot 0 holds both pipes for several cycles |
| s0Fwd | input | 1 | Slot 0 can forward its loaded value |
| s1Valid | input | 1 | Slot 1 holds an instruction |
| s1Unit | input | 2 | Slot 1 execution unit code |
| s1Both | input | 1 | Slot 1 needs both pipes |
| s1Branch | input | 1 | Slot 1 is a branch |
| s1Multi | input | 1 | Slot 1 holds both pipes for several cycles |
| s1Super | input | 1 | Slot 1 is superscalar and can take a forwarded value |
| s1Dep | input | 1 | Slot 1 reads a register that slot 0 writes |
| issue0 | output | 1 | Slot 0 granted this cycle |
| issue1 | output | 1 | Slot 1 granted this cycle |
| pipe0 | output | 2 | Pipes used by slot 0 (bit 0 S, bit 1 T) |
| pipe1 | output | 2 | Pipes used by slot 1 |
| stall | output | 1 | Slot 0 valid but held |

## Verification
The bench builds the block with its default parameters: gaps of 6, 13 and 7 cycles and a hold of 4 cycles. With these values, all three unit-to-unit transitions, including the longest binary-FP gap, can be measured stall by stall in short directed sequences. The measured stall counts are compared against a reference of the shadow lengths. The hold window and the mid-run reset are reached in a few cycles, so every pairing rule can be checked both in isolation and right after a unit switch.

// File: rtl/gate_pkg.sv
package gate_pkg;
  localparam int NUM_UNITS = 3;

  localparam logic [1:0] UNIT_FX = 2'd0;
  localparam logic [1:0] UNIT_BF = 2'd1;
  localparam logic [1:0] UNIT_DF = 2'd2;

  localparam logic [1:0] PIPE_NONE = 2'b00;
  localparam logic [1:0] PIPE_S    = 2'b01;
  localparam logic [1:0] PIPE_T    = 2'b10;
  localparam logic [1:0] PIPE_ST   = 2'b11;

  // strobes from control to the shadow datapath
  typedef struct packed {
    logic       fire;
    logic [1:0] unit;
    logic       hold;
  } issue_strobe_t;

  // state reported back by the datapath
  typedef struct packed {
    logic [NUM_UNITS-1:0] busy;
    logic                 holding;
  } gate_status_t;

  // the spare unit code folds onto fixed-point
  function automatic logic [1:0] normUnit(input logic [1:0] code);
    return (code == 2'd3) ? UNIT_FX : code;
  endfunction
endpackage

// File: rtl/gate_shadow.sv
module gate_shadow
  import gate_pkg::*;
#(
  parameter int FX_GAP      = 6,
  parameter int BF_GAP      = 13,
  parameter int DF_GAP      = 7,
  parameter int HOLD_CYCLES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  issue_strobe_t strobe,
  output gate_status_t  status
);
  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);

  // one draining shift register per execution unit
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    localparam int LEN = (u == 0) ? FX_GAP : (u == 1) ? BF_GAP : DF_GAP;
    logic [LEN-1:0] stages;
    logic           enter;

    assign enter = strobe.fire && (strobe.unit == 2'(u));

    always_ff @(posedge clk) begin
      if (rst) stages <= '0;
      else     stages <= {stages[LEN-2:0], enter};
    end

    assign status.busy[u] = |stages;
  end

  // remaining cycles during which both pipes stay occupied
  logic [HOLD_W-1:0] holdCnt;

  always_ff @(posedge clk) begin
    if (rst)                             holdCnt <= '0;
    else if (strobe.fire && strobe.hold) holdCnt <= HOLD_W'(HOLD_CYCLES - 1);
    else if (holdCnt != '0)              holdCnt <= holdCnt - 1'b1;
  end

  assign status.holding = (holdCnt != '0);
endmodule

// File: rtl/gate_ctrl.sv
module gate_ctrl
  import gate_pkg::*;
(
  input  logic          s0Valid,
  input  logic [1:0]    s0Unit,
  input  logic          s0Both,
  input  logic          s0Branch,
  input  logic          s0Multi,
  input  logic          s0Fwd,
  input  logic          s1Valid,
  input  logic [1:0]    s1Unit,
  input  logic          s1Both,
  input  logic          s1Branch,
  input  logic          s1Multi,
  input  logic          s1Super,
  input  logic          s1Dep,
  input  gate_status_t  status,
  output logic          issue0,
  output logic          issue1,
  output logic [1:0]    pipe0,
  output logic [1:0]    pipe1,
  output logic          stall,
  output issue_strobe_t strobe
);
  logic [1:0]           unit0, unit1;
  logic [NUM_UNITS-1:0] ownMask;
  logic                 otherBusy;
  logic                 wide0, wide1;
  logic                 depOk, pairOk, slot0Ok;

  always_comb begin
    unit0     = normUnit(s0Unit);
    unit1     = normUnit(s1Unit);
    ownMask   = NUM_UNITS'(1) << unit0;
    otherBusy = |(status.busy & ~ownMask);
    wide0     = s0Both | s0Multi;
    wide1     = s1Both | s1Multi;

    slot0Ok = s0Valid && !status.holding && !otherBusy;

    depOk  = !s1Dep || (s0Fwd && s1Super);
    pairOk = slot0Ok && s1Valid && !wide0 && !wide1 &&
             (unit0 == unit1) && !(s0Branch && s1Branch) && depOk;

    issue0 = slot0Ok;
    issue1 = pairOk;
    pipe0  = !slot0Ok ? PIPE_NONE : (wide0 ? PIPE_ST : PIPE_S);
    pipe1  = pairOk ? PIPE_T : PIPE_NONE;
    stall  = s0Valid && !slot0Ok;

    strobe.fire = slot0Ok;
    strobe.unit = unit0;
    strobe.hold = slot0Ok && s0Multi;
  end
endmodule

// File: rtl/dual_issue_gate.sv
module dual_issue_gate
  import gate_pkg::*;
#(
  parameter int FX_GAP      = 6,
  parameter int BF_GAP      = 13,
  parameter int DF_GAP      = 7,
  parameter int HOLD_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       s0Valid,
  input  logic [1:0] s0Unit,
  input  logic       s0Both,
  input  logic       s0Branch,
  input  logic       s0Multi,
  input  logic       s0Fwd,
  input  logic       s1Valid,
  input  logic [1:0] s1Unit,
  input  logic       s1Both,
  input  logic       s1Branch,
  input  logic       s1Multi,
  input  logic       s1Super,
  input  logic       s1Dep,
  output logic       issue0,
  output logic       issue1,
  output logic [1:0] pipe0,
  output logic [1:0] pipe1,
  output logic       stall
);
  issue_strobe_t strobe;
  gate_status_t  status;

  gate_ctrl u_ctrl (
    .s0Valid(s0Valid), .s0Unit(s0Unit), .s0Both(s0Both), .s0Branch(s0Branch),
    .s0Multi(s0Multi), .s0Fwd(s0Fwd),
    .s1Valid(s1Valid), .s1Unit(s1Unit), .s1Both(s1Both), .s1Branch(s1Branch),
    .s1Multi(s1Multi), .s1Super(s1Super), .s1Dep(s1Dep),
    .status(status),
    .issue0(issue0), .issue1(issue1), .pipe0(pipe0), .pipe1(pipe1),
    .stall(stall), .strobe(strobe)
  );

  gate_shadow #(
    .FX_GAP(FX_GAP), .BF_GAP(BF_GAP), .DF_GAP(DF_GAP), .HOLD_CYCLES(HOLD_CYCLES)
  ) u_shadow (
    .clk(clk), .rst(rst), .strobe(strobe), .status(status)
  );
endmodule

// File: rtl/gate_checker.sv
module gate_checker
  import gate_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       s0Valid,
  input logic [1:0] s0Unit,
  input logic       s0Both,
  input logic       s0Branch,
  input logic       s0Multi,
  input logic       s0Fwd,
  input logic       s1Valid,
  input logic       s1Branch,
  input logic       s1Super,
  input logic       s1Dep,
  input logic       issue0,
  input logic       issue1,
  input logic [1:0] pipe0,
  input logic [1:0] pipe1
);
  assert_pair_pipes_R2: assert property (@(posedge clk) disable iff (rst)
    issue1 |-> (pipe0 == PIPE_S && pipe1 == PIPE_T));

  assert_wide_alone_R3: assert property (@(posedge clk) disable iff (rst)
    (issue0 && (s0Both || s0Multi)) |-> !issue1);

  assert_branch_pair_R4: assert property (@(posedge clk) disable iff (rst)
    issue1 |-> !(s0Branch && s1Branch));

  assert_in_order_R5: assert property (@(posedge clk) disable iff (rst)
    issue1 |-> (issue0 && s0Valid && s1Valid));

  assert_forward_pair_R6: assert property (@(posedge clk) disable iff (rst)
    (issue1 && s1Dep) |-> (s0Fwd && s1Super));

  assert_unit_switch_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(issue0) && issue0) |->
      (normUnit(s0Unit) == $past(normUnit(s0Unit))));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (issue0 && s0Multi) |=> !issue0);
endmodule

bind dual_issue_gate gate_checker u_gate_checker (
  .clk(clk), .rst(rst),
  .s0Valid(s0Valid), .s0Unit(s0Unit), .s0Both(s0Both), .s0Branch(s0Branch),
  .s0Multi(s0Multi), .s0Fwd(s0Fwd),
  .s1Valid(s1Valid), .s1Branch(s1Branch), .s1Super(s1Super), .s1Dep(s1Dep),
  .issue0(issue0), .issue1(issue1), .pipe0(pipe0), .pipe1(pipe1)
);

// File: tb/dual_issue_gate_bench.sv
module dual_issue_gate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FX_GAP = 6, BF_GAP = 13, DF_GAP = 7, HOLD_CYCLES = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic s0Valid, s0Both, s0Branch, s0Multi, s0Fwd;
  logic s1Valid, s1Both, s1Branch, s1Multi, s1Super, s1Dep;
  logic [1:0] s0Unit, s1Unit;
  logic issue0, issue1, stall;
  logic [1:0] pipe0, pipe1;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dual_issue_gate #(
    .FX_GAP(FX_GAP), .BF_GAP(BF_GAP), .DF_GAP(DF_GAP), .HOLD_CYCLES(HOLD_CYCLES)
  ) u_dual_issue_gate (
    .clk(clk), .rst(rst),
    .s0Valid(s0Valid), .s0Unit(s0Unit), .s0Both(s0Both), .s0Branch(s0Branch),
    .s0Multi(s0Multi), .s0Fwd(s0Fwd),
    .s1Valid(s1Valid), .s1Unit(s1Unit), .s1Both(s1Both), .s1Branch(s1Branch),
    .s1Multi(s1Multi), .s1Super(s1Super), .s1Dep(s1Dep),
    .issue0(issue0), .issue1(issue1), .pipe0(pipe0), .pipe1(pipe1), .stall(stall)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr();
    s0Valid = 0; s0Unit = 0; s0Both = 0; s0Branch = 0; s0Multi = 0; s0Fwd = 0;
    s1Valid = 0; s1Unit = 0; s1Both = 0; s1Branch = 0; s1Multi = 0; s1Super = 0;
    s1Dep = 0;
  endtask

  // advance to just after the next rising edge; inputs change here
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic drain();
    clr();
    repeat (20) tick();
  endtask

  task automatic setPair(input logic [1:0] u0, input logic [1:0] u1);
    clr();
    s0Valid = 1; s0Unit = u0;
    s1Valid = 1; s1Unit = u1;
  endtask

  // issue unit a, then present unit b and count stall cycles until it goes
  task automatic measureGap(input logic [1:0] a, input logic [1:0] b,
                            input int expGap, input string req);
    int n;
    clr(); s0Valid = 1; s0Unit = a;
    #1 chk({req, " first issue"}, issue0, 1);
    tick();
    clr(); s0Valid = 1; s0Unit = b;
    #1;
    n = 0;
    while (!issue0 && n < 40) begin
      chk({req, " stall flag while blocked (R5)"}, stall, 1);
      n++;
      tick();
      #1;
    end
    chk({req, " stall cycles"}, n, expGap);
    tick();
    clr();
  endtask

  task automatic testReset();
    clr();
    #1 chk("R1 reset issue0 idle", issue0, 0);
    chk("R1 reset stall idle", stall, 0);
    // build a decimal shadow, then reset in the middle of it
    tick(); rst = 0;
    s0Valid = 1; s0Unit = 2'd2;
    #1 chk("R1 DF issues", issue0, 1);
    tick(); clr(); rst = 1;
    tick(); rst = 0;
    s0Valid = 1; s0Unit = 2'd0;
    #1 chk("R1 FX issues right after reset", issue0, 1);
    chk("R1 no stall after reset", stall, 0);
    tick(); drain();
  endtask

  task automatic testPair();
    setPair(2'd0, 2'd0);
    #1 chk("R2 pair slot0", issue0, 1);
    chk("R2 pair slot1", issue1, 1);
    chk("R2 pipe0 S", pipe0, 1);
    chk("R2 pipe1 T", pipe1, 2);
    tick();
    clr(); s0Valid = 1; s0Unit = 2'd0;
    #1 chk("R2 lone slot1 pipe none", pipe1, 0);
    tick(); drain();
  endtask

  task automatic testWide();
    setPair(2'd0, 2'd0); s0Both = 1;
    #1 chk("R3 both-class slot0 issues", issue0, 1);
    chk("R3 both-class alone", issue1, 0);
    chk("R3 both-class pipes", pipe0, 3);
    tick();
    setPair(2'd0, 2'd0); s1Both = 1;
    #1 chk("R3 slot1 both not paired", issue1, 0);
    chk("R3 slot0 still issues", issue0, 1);
    tick();
    setPair(2'd0, 2'd0); s1Multi = 1;
    #1 chk("R3 slot1 multi not paired", issue1, 0);
    tick(); drain();
  endtask

  task automatic testBranch();
    setPair(2'd0, 2'd0); s0Branch = 1; s1Branch = 1;
    #1 chk("R4 two branches slot0", issue0, 1);
    chk("R4 two branches not paired", issue1, 0);
    tick();
    setPair(2'd0, 2'd0); s1Branch = 1;
    #1 chk("R4 branch pairs with non-branch", issue1, 1);
    tick(); drain();
  endtask

  task automatic testOrder();
    // slot0 blocked by a binary-FP shadow: slot1 must not slip ahead
    clr(); s0Valid = 1; s0Unit = 2'd1;
    #1 chk("R5 BF issue", issue0, 1);
    tick();
    setPair(2'd0, 2'd0);
    #1 chk("R5 slot0 stalled", issue0, 0);
    chk("R5 slot1 not alone", issue1, 0);
    chk("R5 stall flag", stall, 1);
    chk("R5 pipe0 none", pipe0, 0);
    tick(); drain();
  endtask

  task automatic testForward();
    setPair(2'd0, 2'd0); s1Dep = 1;
    #1 chk("R6 dependent pair refused", issue1, 0);
    chk("R6 producer issues", issue0, 1);
    tick();
    setPair(2'd0, 2'd0); s1Dep = 1; s0Fwd = 1;
    #1 chk("R6 forward without superscalar refused", issue1, 0);
    tick();
    setPair(2'd0, 2'd0); s1Dep = 1; s1Super = 1;
    #1 chk("R6 superscalar without forward refused", issue1, 0);
    tick();
    setPair(2'd0, 2'd0); s1Dep = 1; s0Fwd = 1; s1Super = 1;
    #1 chk("R6 forwarded pair issues", issue1, 1);
    tick(); drain();
  endtask

  task automatic testGaps();
    measureGap(2'd0, 2'd1, FX_GAP, "R7 FX->BF");
    measureGap(2'd1, 2'd2, BF_GAP, "R7 BF->DF");
    measureGap(2'd2, 2'd0, DF_GAP, "R7 DF->FX");
    drain();
    measureGap(2'd3, 2'd1, FX_GAP, "R11 code3->BF");
    drain();
  endtask

  task automatic testSameUnit();
    for (int u = 0; u < 3; u++) begin
      clr(); s0Valid = 1; s0Unit = 2'(u);
      for (int k = 0; k < 3; k++) begin
        #1 chk("R8 same-unit back-to-back", issue0, 1);
        tick();
      end
      drain();
    end
    clr(); s0Valid = 1; s0Unit = 2'd3;
    #1 chk("R11 code3 issues", issue0, 1);
    tick();
    s0Unit = 2'd0;
    #1 chk("R11 FX right after code3", issue0, 1);
    tick();
    setPair(2'd3, 2'd0);
    #1 chk("R11 code3 pairs with FX", issue1, 1);
    tick(); drain();
  endtask

  task automatic testHold();
    int n;
    clr(); s0Valid = 1; s0Multi = 1;
    #1 chk("R9 multi issues", issue0, 1);
    chk("R9 multi uses both pipes", pipe0, 3);
    tick();
    clr(); s0Valid = 1;
    #1;
    n = 0;
    while (!issue0 && n < 20) begin n++; tick(); #1; end
    chk("R9 hold cycles", n, HOLD_CYCLES - 1);
    tick(); drain();
  endtask

  task automatic testMixedUnits();
    setPair(2'd0, 2'd2);
    #1 chk("R10 mixed pair slot0", issue0, 1);
    chk("R10 mixed pair slot1 held", issue1, 0);
    tick();
    drain();
    setPair(2'd1, 2'd1);
    #1 chk("R10 same non-FX unit pairs", issue1, 1);
    tick(); drain();
  endtask

  initial begin
    clr();
    repeat (3) @(posedge clk);
    #2;
    testReset();
    testPair();
    testWide();
    testBranch();
    testOrder();
    testForward();
    testGaps();
    testSameUnit();
    testHold();
    testMixedUnits();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule